// File: doc/BRIEF.md
# Multi-Sample Correlated Double Sampler

This block takes digitized samples from a row of parallel column channels and turns them into one signal value per pixel. During a row, the row controller first raises a pre-window strobe on each of eight sample cycles, before the pixels are cleared. It then raises a post-window strobe on eight sample cycles after the clear. Every channel sums its samples on the same cycles. When the eighth post-clear sample arrives, each channel forms the mean of the pre-clear samples, subtracts the mean of the post-clear samples, and hands the signed result to an output bank.

The bank then streams the whole row out through one serial port with a valid/ready handshake, channel 0 first. A flag marks the final channel of the row. Acquisition of the next row can run while the current row streams. A row whose pre-window opens before the stream has finished raises a one-cycle overrun pulse. If that row completes while the stream is still busy, it is dropped.

With 64 channels, a row takes 16 sample cycles plus 64 output beats. This fits comfortably in a row time of about 12 µs at a 10 MHz clock.

Top module: `cds_row_proc`

## Requirements
- R1: Channel c's 14-bit unsigned sample sits in bits [c*14 +: 14] of `smp_data`. All channels capture on the same cycle whenever a strobe is accepted.
- R2: In each row, the first eight cycles with `pre_en` high are summed per channel. Further `pre_en` cycles before the row completes are ignored.
- R3: `post_en` cycles are counted only once eight pre samples are held. Of those, the first eight are summed. `post_en` cycles before that point, or after the row completes, are ignored.
- R4: Each channel's result equals floor(pre_sum/8) minus floor(post_sum/8), as a 15-bit two's-complement value.
- R5: If the stream is idle, `res_valid` rises two clock edges after the edge that accepts the eighth post sample. The row then leaves channel 0 first, in ascending channel order, one channel per cycle in which `res_valid` and `res_ready` are both high.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold their values.
- R7: `res_last` is high only on the beat of the highest channel. After that beat is accepted, `res_valid` is low on the next cycle.
- R8: A `pre_en` that opens a new row while the stream is active, or while a completed row is waiting to load, makes `ovr` high for exactly one cycle, the cycle after that edge. Otherwise `ovr` stays low.
- R9: A row that completes while the previous row is still streaming is discarded and never appears at the output.
- R10: During and right after reset, `res_valid` and `ovr` are low and no partial row is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_data | input | 896 | All channel samples, 14 bits per channel |
| pre_en | input | 1 | Pre-clear sample strobe |
| post_en | input | 1 | Post-clear sample strobe |
| res_valid | output | 1 | Output beat valid |
| res_ready | input | 1 | Consumer accepts the beat |
| res_data | output | 15 | Signed per-channel result |
| res_last | output | 1 | Beat carries the highest channel |
| ovr | output | 1 | One-cycle overrun pulse |

## Verification
A wrong sample count or accumulator start shows up as wrong data values in the first row streamed after the fault. It is visible on channel 0, a few cycles after that row completes. A wrong channel index or shift order breaks the channel-by-channel comparison, or moves `res_last` off the final beat. A serializer busy state that ends early or late shows up within one row as missing or extra beats, or as a missing or spurious overrun pulse.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic {
    SER_IDLE   = 1'b0,
    SER_STREAM = 1'b1
  } ser_state_e;

endpackage

// File: rtl/cds_seq.sv
module cds_seq #(
  parameter int N_SMP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_en,
  input  logic post_en,
  output logic pre_take,
  output logic pre_first,
  output logic post_take,
  output logic post_first,
  output logic row_start,
  output logic row_done
);

  localparam int CW = $clog2(N_SMP) + 1;
  localparam logic [CW-1:0] FULL  = CW'(N_SMP);
  localparam logic [CW-1:0] LASTP = CW'(N_SMP - 1);

  logic [CW-1:0] pre_cnt_q, pre_cnt_d;
  logic [CW-1:0] post_cnt_q, post_cnt_d;
  logic          done_q, done_d;

  always_comb begin
    pre_take   = pre_en && (pre_cnt_q != FULL);
    pre_first  = pre_take && (pre_cnt_q == '0);
    post_take  = post_en && (pre_cnt_q == FULL) && (post_cnt_q != FULL);
    post_first = post_take && (post_cnt_q == '0);
    done_d     = post_take && (post_cnt_q == LASTP);
    pre_cnt_d  = pre_cnt_q;
    post_cnt_d = post_cnt_q;
    if (done_d) begin
      pre_cnt_d  = '0;
      post_cnt_d = '0;
    end else begin
      if (pre_take)  pre_cnt_d  = pre_cnt_q + 1'b1;
      if (post_take) post_cnt_d = post_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q  <= '0;
      post_cnt_q <= '0;
      done_q     <= 1'b0;
    end else begin
      pre_cnt_q  <= pre_cnt_d;
      post_cnt_q <= post_cnt_d;
      done_q     <= done_d;
    end
  end

  assign row_start = pre_first;
  assign row_done  = done_q;

endmodule

// File: rtl/cds_chan.sv
module cds_chan #(
  parameter int SAMP_W = 14,
  parameter int N_SMP  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMP_W-1:0]   sample,
  input  logic                pre_take,
  input  logic                pre_first,
  input  logic                post_take,
  input  logic                post_first,
  output logic [SAMP_W:0]     diff
);

  localparam int SH    = $clog2(N_SMP);
  localparam int ACC_W = SAMP_W + SH;

  logic [ACC_W-1:0]  acc_pre_q, acc_pre_d;
  logic [ACC_W-1:0]  acc_post_q, acc_post_d;
  logic [ACC_W-1:0]  ext;
  logic [ACC_W-1:0]  mean_pre_full, mean_post_full;
  logic [SAMP_W-1:0] mean_pre, mean_post;

  always_comb begin
    ext        = ACC_W'(sample);
    acc_pre_d  = acc_pre_q;
    acc_post_d = acc_post_q;
    if (pre_take)  acc_pre_d  = pre_first  ? ext : acc_pre_q + ext;
    if (post_take) acc_post_d = post_first ? ext : acc_post_q + ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_pre_q  <= '0;
      acc_post_q <= '0;
    end else begin
      if (pre_take)  acc_pre_q  <= acc_pre_d;
      if (post_take) acc_post_q <= acc_post_d;
    end
  end

  always_comb begin
    mean_pre_full  = acc_pre_q  >> SH;
    mean_post_full = acc_post_q >> SH;
    mean_pre       = mean_pre_full[SAMP_W-1:0];
    mean_post      = mean_post_full[SAMP_W-1:0];
    diff           = {1'b0, mean_pre} - {1'b0, mean_post};
  end

endmodule

// File: rtl/cds_ser.sv
module cds_ser
  import cds_pkg::*;
#(
  parameter int N_CH   = 64,
  parameter int DATA_W = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [N_CH*DATA_W-1:0]   din,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_last,
  output logic                     busy
);

  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int BW = N_CH * DATA_W;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_CH - 1);

  ser_state_e      state_q, state_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [BW-1:0]   bank_q, bank_d;
  logic            fire;

  always_comb begin
    fire    = (state_q == SER_STREAM) && out_ready;
    state_d = state_q;
    idx_d   = idx_q;
    bank_d  = bank_q;
    if (load && state_q == SER_IDLE) begin
      state_d = SER_STREAM;
      idx_d   = '0;
      bank_d  = din;
    end else if (fire) begin
      bank_d = bank_q >> DATA_W;
      idx_d  = idx_q + 1'b1;
      if (idx_q == LAST_IDX) state_d = SER_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      idx_q   <= '0;
      bank_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bank_q  <= bank_d;
    end
  end

  assign out_valid = (state_q == SER_STREAM);
  assign out_data  = bank_q[DATA_W-1:0];
  assign out_last  = out_valid && (idx_q == LAST_IDX);
  assign busy      = out_valid;

endmodule

// File: rtl/cds_row_proc.sv
module cds_row_proc #(
  parameter int N_CH   = 64,
  parameter int SAMP_W = 14,
  parameter int N_SMP  = 8,
  localparam int DIFF_W = SAMP_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH*SAMP_W-1:0]   smp_data,
  input  logic                     pre_en,
  input  logic                     post_en,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [DIFF_W-1:0]        res_data,
  output logic                     res_last,
  output logic                     ovr
);

  logic rst_meta_q, rst_sync_n;
  logic pre_take, pre_first, post_take, post_first;
  logic row_start, row_done;
  logic ser_busy, ser_load;
  logic ovr_q, ovr_d;
  logic [N_CH*DIFF_W-1:0] row_diff;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cds_seq #(.N_SMP(N_SMP)) i_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pre_en     (pre_en),
    .post_en    (post_en),
    .pre_take   (pre_take),
    .pre_first  (pre_first),
    .post_take  (post_take),
    .post_first (post_first),
    .row_start  (row_start),
    .row_done   (row_done)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    cds_chan #(.SAMP_W(SAMP_W), .N_SMP(N_SMP)) i_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .sample     (smp_data[c*SAMP_W +: SAMP_W]),
      .pre_take   (pre_take),
      .pre_first  (pre_first),
      .post_take  (post_take),
      .post_first (post_first),
      .diff       (row_diff[c*DIFF_W +: DIFF_W])
    );
  end

  // a finished row loads only into an idle stream, otherwise it is dropped
  assign ser_load = row_done && !ser_busy;

  cds_ser #(.N_CH(N_CH), .DATA_W(DIFF_W)) i_ser (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (ser_load),
    .din       (row_diff),
    .out_ready (res_ready),
    .out_valid (res_valid),
    .out_data  (res_data),
    .out_last  (res_last),
    .busy      (ser_busy)
  );

  always_comb begin
    ovr_d = row_start && (ser_busy || row_done);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovr_q <= 1'b0;
    else             ovr_q <= ovr_d;
  end

  assign ovr = ovr_q;

endmodule

// File: rtl/cds_row_proc_chk.sv
module cds_row_proc_chk #(
  parameter int DIFF_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pre_en,
  input logic              post_en,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DIFF_W-1:0] res_data,
  input logic              res_last,
  input logic              ovr
);

  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |-> res_valid);

  assert_valid_drops_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_last) |=> !res_valid);

  assert_stream_follows_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(post_en, 2));

  assert_ovr_follows_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> $past(pre_en));

  assert_ovr_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> !ovr);

endmodule

bind cds_row_proc cds_row_proc_chk #(.DIFF_W(DIFF_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pre_en    (pre_en),
  .post_en   (post_en),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_last  (res_last),
  .ovr       (ovr)
);

// File: tb/test_cds_row_proc.sv
module test_cds_row_proc;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int SW  = 14;
  localparam int NS  = 8;
  localparam int DW  = 15;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NCH*SW-1:0]   smp_data = '0;
  logic                pre_en = 1'b0;
  logic                post_en = 1'b0;
  logic                res_ready = 1'b0;
  logic                res_valid;
  logic [DW-1:0]       res_data;
  logic                res_last;
  logic                ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cds_row_proc i_cds_row_proc (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_data  (smp_data),
    .pre_en    (pre_en),
    .post_en   (post_en),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_last  (res_last),
    .ovr       (ovr)
  );

  typedef struct {
    logic [DW-1:0] d;
    bit            l;
    int            ch;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   ovr_seen = 0;
  int   cyc = 0;
  bit   stall = 1'b0;
  bit   rdy_next;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int smp(input int mode, input int seed, input int ch,
                             input int k, input bit post);
    case (mode)
      1: return post ? 0 : 16383;
      2: return post ? 16383 : 0;
      3: return 0;
      default: return ((seed*7919 + ch*613 + k*97 + (post ? 4021 : 0)) * 13) % 16384;
    endcase
  endfunction

  // scoreboard monitor: checks each beat that will be accepted at the next edge
  always @(negedge clk) begin
    if (rst_n && ovr) ovr_seen++;
    rdy_next = stall ? 1'b0 : (lfsr[0] | lfsr[3]);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n && res_valid && rdy_next) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R9 unexpected beat", int'(res_data), 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(res_data == e.d, $sformatf("R4/R5 data ch%0d", e.ch),
            int'($signed(res_data)), int'($signed(e.d)));
        chk(res_last == e.l, $sformatf("R7 last ch%0d", e.ch),
            int'(res_last), int'(e.l));
      end
    end
    res_ready <= rdy_next;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // R1 R2 R3: drives one row; keep=0 means the row is expected to be dropped
  task automatic run_row(input int mode, input int seed, input int extra_pre,
                         input bit early_post, input bit keep);
    if (keep) begin
      for (int ch = 0; ch < NCH; ch++) begin
        int sp, sq, dv;
        exp_t e;
        sp = 0; sq = 0;
        for (int k = 0; k < NS; k++) begin
          sp += smp(mode, seed, ch, k, 1'b0);
          sq += smp(mode, seed, ch, k, 1'b1);
        end
        dv = (sp >>> 3) - (sq >>> 3);
        e.d = dv[DW-1:0];
        e.l = (ch == NCH-1);
        e.ch = ch;
        sbq.push_back(e);
      end
    end
    if (early_post) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        post_en = 1'b1;
        for (int ch = 0; ch < NCH; ch++) smp_data[ch*SW +: SW] = 14'h3FFF;
      end
      @(negedge clk);
      post_en = 1'b0;
    end
    for (int k = 0; k < NS + extra_pre; k++) begin
      @(negedge clk);
      pre_en = 1'b1;
      for (int ch = 0; ch < NCH; ch++)
        smp_data[ch*SW +: SW] = (k < NS) ? SW'(smp(mode, seed, ch, k, 1'b0)) : 14'h2AAA;
    end
    @(negedge clk);
    pre_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      post_en = 1'b1;
      for (int ch = 0; ch < NCH; ch++)
        smp_data[ch*SW +: SW] = SW'(smp(mode, seed, ch, k, 1'b1));
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) smp_data[ch*SW +: SW] = 14'h1555;
    end
    @(negedge clk);
    post_en = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0 || res_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(res_valid == 1'b0, "R10 valid in reset", int'(res_valid), 0);
    chk(ovr == 1'b0, "R10 ovr in reset", int'(ovr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(res_valid == 1'b0, "R10 valid after reset", int'(res_valid), 0);

    run_row(3, 0, 0, 1'b0, 1'b1);   // all zero
    drain();
    run_row(1, 0, 0, 1'b0, 1'b1);   // largest positive result
    drain();
    run_row(2, 0, 0, 1'b0, 1'b1);   // largest negative result
    drain();
    run_row(0, 5, 3, 1'b1, 1'b1);   // R2 extra pre, R3 early post ignored
    drain();
    run_row(0, 9, 0, 1'b0, 1'b1);
    drain();
    chk(ovr_seen == 0, "R8 no overrun on spaced rows", ovr_seen, 0);

    stall = 1'b1;
    run_row(0, 11, 0, 1'b0, 1'b1);
    chk(res_valid == 1'b1, "R5 valid after row", int'(res_valid), 1);
    repeat (4) @(negedge clk);
    chk(res_valid == 1'b1, "R6 valid held under stall", int'(res_valid), 1);
    run_row(0, 12, 0, 1'b0, 1'b0);  // R9 completes while streaming: dropped
    chk(ovr_seen == 1, "R8 overrun pulse", ovr_seen, 1);
    stall = 1'b0;
    drain();
    chk(sbq.size() == 0, "R9 queue empty", sbq.size(), 0);
    chk(res_valid == 1'b0, "R7 idle after last", int'(res_valid), 0);

    run_row(0, 13, 0, 1'b0, 1'b1);
    drain();
    chk(ovr_seen == 1, "R8 no further overrun", ovr_seen, 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule